// File: doc/BRIEF.md
# Wavelet Modulus-Maxima Pair Beat Decider

This block sits after the wavelet filter and feature extractors of a heartbeat detector. Each clock cycle carries one sample. The upstream logic reports three things for that sample: a zero-crossing flag, a two-bit peak code with the peak amplitude, and the current positive and negative thresholds. The block decides whether a large excursion of one polarity, followed by a large excursion of the other polarity, forms a valid beat. It then marks the time of the beat.

Two state machines share the work. The pair recogniser waits for a qualifying peak and then for a zero crossing. It then waits for a qualifying peak of the opposite sign, and it may also accept that opposite peak without the zero crossing. It gives up after a parameterised timeout. Once a pair completes, it blanks all input for a refractory window. It raises a one-cycle candidate flag when the zero crossing (or the direct pair) is seen, and it holds a confirm flag for the whole blanking window. The marker machine starts a fixed delay on the candidate flag and samples the confirm flag when the delay ends. It produces a one-cycle beat pulse only when the pair was confirmed by then. The beat pulse therefore sits at a fixed offset after the zero crossing.

Top module: `beat_pair_decider`

## Requirements
- R1: While reset is asserted, and after reset until the first qualifying peak, cand_o, conf_o and beat_o are low and both machines are idle.
- R2: A peak qualifies only under one of two rules. Code 2'b01 (upward) qualifies when its amplitude is strictly greater than thr_pos_i. Code 2'b10 (downward) qualifies when its amplitude is strictly less than thr_neg_i. Equal amplitudes and codes 2'b00 and 2'b11 never qualify. A qualifying peak moves the idle recogniser to the peak-seen state and records its polarity.
- R3: A zero crossing sampled in the peak-seen state moves the recogniser to the zero-seen state. cand_o is then high for exactly one cycle, in the cycle after that sample.
- R4: A qualifying peak of the opposite polarity to the recorded one, sampled in either peak-seen or zero-seen, moves the recogniser to the opposite-seen state. When this is taken directly from peak-seen, cand_o also pulses for one cycle in the cycle after that sample. It wins over a zero crossing in the same sample. Peaks of the recorded polarity have no effect.
- R5: conf_o is high exactly while the recogniser is in opposite-seen. This lasts REFR_LEN consecutive cycles (default 25), beginning the cycle after the opposite peak, and the recogniser is then idle.
- R6: If the recogniser spends TOUT_LEN cycles (default 21) in peak-seen or zero-seen without progressing, it returns to idle. An event sampled in the last of those cycles still counts; one sampled in the cycle after does not.
- R7: Zero crossings and peaks sampled while the recogniser is in opposite-seen have no effect. Zero crossings sampled while it is idle have no effect.
- R8: A cand_o pulse in cycle c starts the marker. If conf_o is high in cycle c+MARK_DLY+1 (default MARK_DLY 10), beat_o is high in that cycle.
- R9: If conf_o is low in the marker's check cycle, no beat pulse is produced for that candidate, even if the opposite peak arrives later.
- R10: beat_o is never high for two consecutive cycles, and at most one beat follows each candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| zc_i | input | 1 | Zero crossing seen in this sample |
| pk_code_i | input | 2 | Peak code: 00 none, 01 upward, 10 downward, 11 none |
| pk_amp_i | input | AMP_W | Signed amplitude of the reported peak |
| thr_pos_i | input | AMP_W | Signed threshold for upward peaks |
| thr_neg_i | input | AMP_W | Signed threshold for downward peaks (normally negative) |
| cand_o | output | 1 | One-cycle candidate flag at the zero crossing or direct pair |
| conf_o | output | 1 | Confirm flag, high during refractory blanking |
| beat_o | output | 1 | One-cycle beat indication, fixed delay after the candidate |

## Verification
Several properties are checked on every cycle. The candidate and beat pulses last one cycle. A beat appears only MARK_DLY+1 cycles after a candidate, and only while the pair is confirmed. Every confirm window is exactly REFR_LEN cycles long. The bench scenarios are needed for behaviour that depends on input history: threshold equality, reserved peak codes, ignored zero crossings in idle, same-polarity peaks, the exact timeout boundary, and a confirmation that arrives one cycle too late to be marked.

// File: rtl/bpd_pkg.sv
package bpd_pkg;

   typedef enum logic [1:0] {
      PS_IDLE = 2'd0,
      PS_PEAK = 2'd1,
      PS_ZERO = 2'd2,
      PS_OPP  = 2'd3
   } pair_st_t;

   typedef enum logic [1:0] {
      MS_IDLE = 2'd0,
      MS_CAND = 2'd1,
      MS_CHK  = 2'd2
   } mark_st_t;

   localparam logic [1:0] PK_NONE = 2'b00;
   localparam logic [1:0] PK_UP   = 2'b01;
   localparam logic [1:0] PK_DN   = 2'b10;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/bpd_peak_qual.sv
module bpd_peak_qual #(
   parameter int AMP_W  = 14,
   parameter bit STRICT = 1'b1
) (
   input  logic [1:0]              code_i,
   input  logic signed [AMP_W-1:0] amp_i,
   input  logic signed [AMP_W-1:0] thr_pos_i,
   input  logic signed [AMP_W-1:0] thr_neg_i,
   output logic                    up_ok_o,
   output logic                    dn_ok_o
);
   import bpd_pkg::*;

   logic above_pos;
   logic below_neg;

   generate
      if (STRICT) begin : g_strict
         assign above_pos = (amp_i > thr_pos_i);
         assign below_neg = (amp_i < thr_neg_i);
      end else begin : g_inclusive
         assign above_pos = (amp_i >= thr_pos_i);
         assign below_neg = (amp_i <= thr_neg_i);
      end
   endgenerate

   assign up_ok_o = (code_i == PK_UP) && above_pos;
   assign dn_ok_o = (code_i == PK_DN) && below_neg;

endmodule

// File: rtl/bpd_pair_fsm.sv
module bpd_pair_fsm #(
   parameter int TOUT_LEN = 21,
   parameter int REFR_LEN = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic zc_i,
   input  logic up_ok_i,
   input  logic dn_ok_i,
   output logic cand_o,
   output logic conf_o
);
   import bpd_pkg::*;

   localparam int CNT_MAX = max2(TOUT_LEN, REFR_LEN);
   localparam int CNT_W   = $clog2(CNT_MAX);
   localparam logic [CNT_W-1:0] TOUT_LAST = CNT_W'(TOUT_LEN - 1);
   localparam logic [CNT_W-1:0] REFR_LAST = CNT_W'(REFR_LEN - 1);

   pair_st_t         st_q, st_d;
   logic             pol_up_q, pol_up_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             cand_q, cand_d;
   logic             opp_ok;

   assign opp_ok = pol_up_q ? dn_ok_i : up_ok_i;

   always_comb begin
      st_d     = st_q;
      pol_up_d = pol_up_q;
      cnt_d    = cnt_q;
      cand_d   = 1'b0;
      unique case (st_q)
         PS_IDLE: begin
            cnt_d = '0;
            if (up_ok_i) begin
               st_d     = PS_PEAK;
               pol_up_d = 1'b1;
            end else if (dn_ok_i) begin
               st_d     = PS_PEAK;
               pol_up_d = 1'b0;
            end
         end
         PS_PEAK: begin
            if (opp_ok) begin
               st_d   = PS_OPP;
               cand_d = 1'b1;
               cnt_d  = '0;
            end else if (zc_i) begin
               st_d   = PS_ZERO;
               cand_d = 1'b1;
               cnt_d  = '0;
            end else if (cnt_q == TOUT_LAST) begin
               st_d  = PS_IDLE;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         PS_ZERO: begin
            if (opp_ok) begin
               st_d  = PS_OPP;
               cnt_d = '0;
            end else if (cnt_q == TOUT_LAST) begin
               st_d  = PS_IDLE;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         PS_OPP: begin
            if (cnt_q == REFR_LAST) begin
               st_d  = PS_IDLE;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: begin
            st_d  = PS_IDLE;
            cnt_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= PS_IDLE;
         pol_up_q <= 1'b0;
         cnt_q    <= '0;
         cand_q   <= 1'b0;
      end else begin
         st_q     <= st_d;
         pol_up_q <= pol_up_d;
         cnt_q    <= cnt_d;
         cand_q   <= cand_d;
      end
   end

   assign cand_o = cand_q;
   assign conf_o = (st_q == PS_OPP);

endmodule

// File: rtl/bpd_mark_fsm.sv
module bpd_mark_fsm #(
   parameter int MARK_DLY = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cand_i,
   input  logic conf_i,
   output logic beat_o
);
   import bpd_pkg::*;

   localparam int DW = (MARK_DLY > 1) ? $clog2(MARK_DLY) : 1;
   localparam logic [DW-1:0] DLY_LAST = DW'(MARK_DLY - 1);

   mark_st_t      mst_q, mst_d;
   logic [DW-1:0] dcnt_q, dcnt_d;

   always_comb begin
      mst_d  = mst_q;
      dcnt_d = dcnt_q;
      unique case (mst_q)
         MS_IDLE: begin
            dcnt_d = '0;
            if (cand_i) mst_d = MS_CAND;
         end
         MS_CAND: begin
            if (dcnt_q == DLY_LAST) begin
               mst_d  = MS_CHK;
               dcnt_d = '0;
            end else begin
               dcnt_d = dcnt_q + 1'b1;
            end
         end
         MS_CHK: begin
            mst_d  = MS_IDLE;
            dcnt_d = '0;
         end
         default: begin
            mst_d  = MS_IDLE;
            dcnt_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mst_q  <= MS_IDLE;
         dcnt_q <= '0;
      end else begin
         mst_q  <= mst_d;
         dcnt_q <= dcnt_d;
      end
   end

   assign beat_o = (mst_q == MS_CHK) && conf_i;

endmodule

// File: rtl/beat_pair_decider.sv
module beat_pair_decider #(
   parameter int AMP_W       = 14,
   parameter int TOUT_LEN    = 21,
   parameter int REFR_LEN    = 25,
   parameter int MARK_DLY    = 10,
   parameter bit STRICT_QUAL = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    zc_i,
   input  logic [1:0]              pk_code_i,
   input  logic signed [AMP_W-1:0] pk_amp_i,
   input  logic signed [AMP_W-1:0] thr_pos_i,
   input  logic signed [AMP_W-1:0] thr_neg_i,
   output logic                    cand_o,
   output logic                    conf_o,
   output logic                    beat_o
);

   generate
      if (AMP_W < 2) begin : g_bad_amp
         $error("AMP_W must be at least 2");
      end
      if (TOUT_LEN < 2) begin : g_bad_tout
         $error("TOUT_LEN must be at least 2");
      end
      if (MARK_DLY < 1) begin : g_bad_dly
         $error("MARK_DLY must be at least 1");
      end
      if (MARK_DLY + 2 > REFR_LEN) begin : g_bad_refr
         $error("REFR_LEN must cover the marking delay plus the check cycle");
      end
      if (MARK_DLY >= TOUT_LEN) begin : g_bad_mark
         $error("MARK_DLY must be shorter than TOUT_LEN");
      end
   endgenerate

   logic up_ok;
   logic dn_ok;

   bpd_peak_qual #(
      .AMP_W (AMP_W),
      .STRICT(STRICT_QUAL)
   ) u_qual (
      .code_i   (pk_code_i),
      .amp_i    (pk_amp_i),
      .thr_pos_i(thr_pos_i),
      .thr_neg_i(thr_neg_i),
      .up_ok_o  (up_ok),
      .dn_ok_o  (dn_ok)
   );

   bpd_pair_fsm #(
      .TOUT_LEN(TOUT_LEN),
      .REFR_LEN(REFR_LEN)
   ) u_pair (
      .clk    (clk),
      .rst_n  (rst_n),
      .zc_i   (zc_i),
      .up_ok_i(up_ok),
      .dn_ok_i(dn_ok),
      .cand_o (cand_o),
      .conf_o (conf_o)
   );

   bpd_mark_fsm #(
      .MARK_DLY(MARK_DLY)
   ) u_mark (
      .clk   (clk),
      .rst_n (rst_n),
      .cand_i(cand_o),
      .conf_i(conf_o),
      .beat_o(beat_o)
   );

endmodule

// File: rtl/bpd_checker.sv
module bpd_checker #(
   parameter int REFR_LEN = 25,
   parameter int MARK_DLY = 10
) (
   input logic clk,
   input logic rst_n,
   input logic cand_o,
   input logic conf_o,
   input logic beat_o
);
   localparam int SW = $clog2(MARK_DLY + 3) + 1;
   localparam int RW = $clog2(REFR_LEN + 2) + 1;
   localparam logic [SW-1:0] SINCE_CAP = SW'(MARK_DLY + 2);

   logic [SW-1:0] since_cand;
   logic [RW-1:0] conf_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_cand <= '0;
         conf_run   <= '0;
      end else begin
         if (cand_o) since_cand <= SW'(1);
         else if (since_cand != '0 && since_cand != SINCE_CAP) since_cand <= since_cand + 1'b1;
         if (conf_o) conf_run <= conf_run + 1'b1;
         else conf_run <= '0;
      end
   end

   AST_CAND_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cand_o |=> !cand_o); // R3

   AST_BEAT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      beat_o |=> !beat_o); // R10

   AST_BEAT_NEEDS_CONF: assert property (@(posedge clk) disable iff (!rst_n)
      beat_o |-> conf_o); // R9

   AST_BEAT_FIXED_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      beat_o |-> (since_cand == SW'(MARK_DLY + 1))); // R8

   AST_CONF_NOT_LONGER: assert property (@(posedge clk) disable iff (!rst_n)
      conf_o |-> (conf_run < RW'(REFR_LEN))); // R5

   AST_CONF_FULL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(conf_o) |-> (conf_run == RW'(REFR_LEN))); // R5

endmodule

bind beat_pair_decider bpd_checker #(
   .REFR_LEN(REFR_LEN),
   .MARK_DLY(MARK_DLY)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .cand_o(cand_o),
   .conf_o(conf_o),
   .beat_o(beat_o)
);

// File: tb/beat_pair_decider_tb_top.sv
module beat_pair_decider_tb_top;
   localparam int CLK_PER  = 10;
   localparam int AMP_W    = 14;
   localparam int TOUT_LEN = 21;
   localparam int REFR_LEN = 25;
   localparam int MARK_DLY = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic zc_i = 1'b0;
   logic [1:0] pk_code_i = 2'b00;
   logic signed [AMP_W-1:0] pk_amp_i = '0;
   logic signed [AMP_W-1:0] thr_pos_i = AMP_W'(300);
   logic signed [AMP_W-1:0] thr_neg_i = -AMP_W'(300);
   logic cand_o, conf_o, beat_o;

   int cyc = 0;
   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;
   int exp_cand[$];
   int exp_beat[$];
   int exp_conf[$];
   bit conf_prev = 1'b0;
   int conf_len = 0;

   always #(CLK_PER/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   beat_pair_decider #(
      .AMP_W(AMP_W), .TOUT_LEN(TOUT_LEN), .REFR_LEN(REFR_LEN), .MARK_DLY(MARK_DLY)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .zc_i(zc_i), .pk_code_i(pk_code_i), .pk_amp_i(pk_amp_i),
      .thr_pos_i(thr_pos_i), .thr_neg_i(thr_neg_i),
      .cand_o(cand_o), .conf_o(conf_o), .beat_o(beat_o)
   );

   // Monitor: pops expected event cycles and compares with the outputs.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         // R3 and R4: candidate pulses
         if (exp_cand.size() > 0 && exp_cand[0] == cyc) begin
            void'(exp_cand.pop_front());
            vectors++;
            if (!cand_o) begin
               miscompares++;
               $display("FAIL R3 cand cycle %0d: actual=0 expected=1", cyc);
            end
         end else if (cand_o) begin
            vectors++; miscompares++;
            $display("FAIL R3 cand cycle %0d: actual=1 expected=0", cyc);
         end
         // R8 and R9: beat pulses
         if (exp_beat.size() > 0 && exp_beat[0] == cyc) begin
            void'(exp_beat.pop_front());
            vectors++;
            if (!beat_o) begin
               miscompares++;
               $display("FAIL R8 beat cycle %0d: actual=0 expected=1", cyc);
            end
         end else if (beat_o) begin
            vectors++; miscompares++;
            $display("FAIL R9 beat cycle %0d: actual=1 expected=0", cyc);
         end
         // R5: confirm window start and length
         if (exp_conf.size() > 0 && exp_conf[0] == cyc) begin
            void'(exp_conf.pop_front());
            vectors++;
            if (!(conf_o && !conf_prev)) begin
               miscompares++;
               $display("FAIL R5 conf rise cycle %0d: actual=%0b expected=1", cyc, conf_o && !conf_prev);
            end
         end else if (conf_o && !conf_prev) begin
            vectors++; miscompares++;
            $display("FAIL R5 conf rise cycle %0d: actual=1 expected=0", cyc);
         end
         if (conf_o) conf_len++;
         else if (conf_prev) begin
            vectors++;
            if (conf_len != REFR_LEN) begin
               miscompares++;
               $display("FAIL R5 conf length: actual=%0d expected=%0d", conf_len, REFR_LEN);
            end
            conf_len = 0;
         end
         conf_prev = conf_o;
      end
   end

   task automatic step(input logic z, input logic [1:0] c, input int a, output int n);
      @(negedge clk);
      zc_i = z;
      pk_code_i = c;
      pk_amp_i = AMP_W'(a);
      n = cyc;
   endtask

   task automatic idle(input int k);
      int n;
      for (int i = 0; i < k; i++) step(1'b0, 2'b00, 0, n);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PER * 150000);
      miscompares++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int n;
      int c;
      // R1: reset state
      repeat (3) @(negedge clk);
      vectors += 3;
      if (cand_o) begin miscompares++; $display("FAIL R1 cand in reset: actual=1 expected=0"); end
      if (conf_o) begin miscompares++; $display("FAIL R1 conf in reset: actual=1 expected=0"); end
      if (beat_o) begin miscompares++; $display("FAIL R1 beat in reset: actual=1 expected=0"); end
      rst_n = 1'b1;
      idle(4);

      // R2 R3 R8: up peak, zero crossing, down peak
      step(1'b0, 2'b01, 500, n);
      idle(1);
      step(1'b1, 2'b00, 0, n);
      c = n + 1; exp_cand.push_back(c); exp_beat.push_back(c + MARK_DLY + 1);
      idle(1);
      step(1'b0, 2'b10, -500, n);
      exp_conf.push_back(n + 1);
      idle(REFR_LEN + 3);

      // R4: direct pair down then up, candidate on the transition
      step(1'b0, 2'b10, -400, n);
      idle(1);
      step(1'b1, 2'b01, 400, n);   // opposite wins over zero crossing
      c = n + 1; exp_cand.push_back(c); exp_conf.push_back(c); exp_beat.push_back(c + MARK_DLY + 1);
      idle(REFR_LEN + 3);

      // R2 R7: equal amplitudes, reserved code, zero crossing in idle are ignored
      step(1'b0, 2'b01, 300, n);
      step(1'b0, 2'b10, -300, n);
      step(1'b0, 2'b11, 900, n);
      step(1'b1, 2'b00, 0, n);
      idle(3);
      // R2 R9: just above threshold, zero crossing, no opposite peak -> no beat
      step(1'b0, 2'b01, 301, n);
      step(1'b1, 2'b00, 0, n);
      exp_cand.push_back(n + 1);
      idle(TOUT_LEN + 3);

      // R6: zero crossing in the last peak-seen cycle still counts
      step(1'b0, 2'b01, 500, n);
      idle(TOUT_LEN - 1);
      step(1'b1, 2'b00, 0, n);
      exp_cand.push_back(n + 1);
      idle(TOUT_LEN + 3);
      // R6 R7: one cycle later the machine is idle and the crossing is ignored
      step(1'b0, 2'b01, 500, n);
      idle(TOUT_LEN);
      step(1'b1, 2'b00, 0, n);
      idle(3);
      // R6: a downward peak after timeout starts a fresh pair (down first)
      step(1'b0, 2'b10, -600, n);
      step(1'b1, 2'b00, 0, n);
      c = n + 1; exp_cand.push_back(c); exp_beat.push_back(c + MARK_DLY + 1);
      step(1'b0, 2'b01, 600, n);
      exp_conf.push_back(n + 1);
      idle(REFR_LEN + 3);

      // R9: opposite peak one cycle too late for the check -> no beat
      step(1'b0, 2'b01, 500, n);
      step(1'b1, 2'b00, 0, n);
      c = n + 1; exp_cand.push_back(c);
      idle(c + MARK_DLY + 1 - (n + 1));
      step(1'b0, 2'b10, -500, n);   // applied in cycle c+MARK_DLY+1
      exp_conf.push_back(n + 1);
      idle(REFR_LEN + 3);

      // R8: opposite peak at the latest cycle still marked
      step(1'b0, 2'b01, 500, n);
      step(1'b1, 2'b00, 0, n);
      c = n + 1; exp_cand.push_back(c); exp_beat.push_back(c + MARK_DLY + 1);
      idle(c + MARK_DLY - (n + 1));
      step(1'b0, 2'b10, -500, n);   // applied in cycle c+MARK_DLY
      exp_conf.push_back(n + 1);
      idle(REFR_LEN + 3);

      // R4: same-polarity peak in peak-seen ignored; R5 R7: input during blanking ignored
      step(1'b0, 2'b01, 500, n);
      step(1'b0, 2'b01, 700, n);
      step(1'b1, 2'b00, 0, n);
      c = n + 1; exp_cand.push_back(c); exp_beat.push_back(c + MARK_DLY + 1);
      step(1'b0, 2'b10, -500, n);
      exp_conf.push_back(n + 1);
      step(1'b0, 2'b01, 800, n);
      step(1'b1, 2'b00, 0, n);
      step(1'b0, 2'b10, -800, n);
      step(1'b1, 2'b01, 800, n);
      idle(REFR_LEN + 3);
      // R10: a fresh pair after blanking gives exactly one beat
      step(1'b0, 2'b01, 500, n);
      step(1'b1, 2'b00, 0, n);
      c = n + 1; exp_cand.push_back(c); exp_beat.push_back(c + MARK_DLY + 1);
      step(1'b0, 2'b10, -500, n);
      exp_conf.push_back(n + 1);
      idle(REFR_LEN + 5);

      vectors++;
      if (exp_cand.size() + exp_beat.size() + exp_conf.size() != 0) begin
         miscompares++;
         $display("FAIL R10 pending events: actual=%0d expected=0",
                  exp_cand.size() + exp_beat.size() + exp_conf.size());
      end
      finish_run();
   end

endmodule